// File: doc/BRIEF.md
# Overcharge Delay and Release Controller

This block is the digital decision logic of a secondary protection monitor for a battery pack of two to four series cells. Each cell has two comparator flags from the analog side: one set while the cell is above its overcharge detection threshold, and one set while it is at or above its release threshold (detection level plus hysteresis). The block turns these flags into one charge-control output. The output moves to its detection level only after an overcharge has been qualified for a strapped delay. It returns to normal only after every cell has stayed below the release level for a second strapped delay.

Every timer advances only on a one-cycle millisecond tick. Short dropouts of the overcharge condition do not restart detection. Only a dropout that lasts the timer-reset time clears the count. An external override input forces the detection level regardless of the timers. A test-entry input, held long enough, sets a latch that shortens the detection delay. The latch clears itself when the shortened delay produces a detection. The straps choose the detection delay, the release delay and the output polarity, and they are captured only while reset is asserted.

Top module: `ovp_ctrl`

## Requirements
- R1: While `rst_ni` is low and after its release, the output sits at the normal level, all timers are clear and test mode is off. The normal level is 0 for `pol_sel_i`=0 and 1 for `pol_sel_i`=1.
- R2: The output goes to the detection level once the overcharge flag has been seen on N counted ticks. N is `MS_PER_S` times 1, 2, 4, 6 or 8 for `det_sel_i` = 0, 1, 2, 3 or 4. Codes 5 to 7 select 8.
- R3: The detection count keeps running through a dropout of the overcharge condition that lasts fewer than `TR_MS` ticks. A dropout of `TR_MS` ticks clears the count, and counting starts again at the next crossing. Any reasserted flag clears the dropout count.
- R4: The output leaves the detection level only after every release flag has been low on M consecutive ticks. M is `REL_SHORT_MS` for `rel_sel_i`=0 and `REL_LONG_MS` for `rel_sel_i`=1.
- R5: Any release flag that rises before M ticks have elapsed clears the release count.
- R6: A high override input (`ctl_i`) forces the detection level within three clock cycles, whatever the timers hold. When the override is low, the detection logic controls the output.
- R7: With `pol_sel_i`=0 the output is 0 in normal status and 1 in detection status. With `pol_sel_i`=1 the levels are swapped.
- R8: Test mode is set once `test_req_i` has been high on `TEST_ENTRY_MS` consecutive ticks. It stays set after `test_req_i` falls. A shorter request has no effect.
- R9: In test mode the detection delay is `TEST_DLY_MS` ticks. The dropout reset time stays `TR_MS`.
- R10: Test mode clears when a detection is reached while it is on. The next detection uses the strapped delay again.
- R11: Strap changes made while reset is deasserted have no effect on delays or polarity.
- R12: An overcharge flag on any single cell is enough to start and complete detection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low; straps are captured while low |
| tick_i | input | 1 | Millisecond tick, one cycle wide, synchronous to clk_i |
| ov_flag_i | input | NUM_CELLS | Per-cell flag: cell above overcharge detection threshold |
| rel_flag_i | input | NUM_CELLS | Per-cell flag: cell at or above release threshold |
| ctl_i | input | 1 | Override: high forces the detection level |
| test_req_i | input | 1 | Test-mode entry request |
| det_sel_i | input | 3 | Strap: detection delay code |
| rel_sel_i | input | 1 | Strap: release delay, 0 short, 1 long |
| pol_sel_i | input | 1 | Strap: output polarity, 0 active high, 1 active low |
| chg_ctl_o | output | 1 | Charge-control output |

## Verification
The bench builds the block with `MS_PER_S`=10, `TR_MS`=4, `REL_SHORT_MS`=2, `REL_LONG_MS`=16, `TEST_ENTRY_MS`=3 and `TEST_DLY_MS`=5. With these values every detection delay code finishes within tens of ticks, so each strap setting can be walked through. Dropouts of one tick below and exactly at the reset time can be placed by hand. The test-mode delay stays shorter than the shortest strapped delay, so a shortened detection can be told apart from a normal one. The long release delay is short enough that release flags can interrupt it repeatedly in random runs.

// File: rtl/ovp_pkg.sv
package ovp_pkg;

  typedef enum logic {
    ST_NORMAL = 1'b0,
    ST_OVCHG  = 1'b1
  } ovp_state_e;

  function automatic int unsigned det_secs(input logic [2:0] sel);
    case (sel)
      3'd0:    return 1;
      3'd1:    return 2;
      3'd2:    return 4;
      3'd3:    return 6;
      default: return 8;
    endcase
  endfunction

endpackage

// File: rtl/ovp_sync.sv
module ovp_sync #(
  parameter int unsigned W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/ovp_det_timer.sv
module ovp_det_timer #(
  parameter int unsigned CW    = 13,
  parameter int unsigned TR_MS = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          tick_i,
  input  logic          ov_i,
  input  logic [CW-1:0] lim_i,
  output logic          expire_o
);
  localparam int unsigned TW = $clog2(TR_MS + 1);

  logic          active_q;
  logic [CW-1:0] cnt_q;
  logic [TW-1:0] drop_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      drop_q   <= '0;
    end else if (!en_i) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      drop_q   <= '0;
    end else begin
      if (ov_i) begin
        active_q <= 1'b1;
        drop_q   <= '0;
      end
      if (tick_i && (active_q || ov_i)) begin
        if (cnt_q < lim_i) cnt_q <= cnt_q + 1'b1;
        if (!ov_i) begin
          // dropout long enough: abandon this detection attempt
          if (drop_q >= TW'(TR_MS - 1)) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
            drop_q   <= '0;
          end else begin
            drop_q <= drop_q + 1'b1;
          end
        end
      end
    end
  end

  assign expire_o = en_i && active_q && ov_i && (cnt_q >= lim_i);
endmodule

// File: rtl/ovp_rel_timer.sv
module ovp_rel_timer #(
  parameter int unsigned RW = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          tick_i,
  input  logic          rel_i,
  input  logic [RW-1:0] lim_i,
  output logic          expire_o
);
  logic [RW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (!en_i || rel_i)           cnt_q <= '0;
    else if (tick_i && cnt_q < lim_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign expire_o = en_i && !rel_i && (cnt_q >= lim_i);
endmodule

// File: rtl/ovp_test_latch.sv
module ovp_test_latch #(
  parameter int unsigned ENTRY_MS = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic req_i,
  input  logic clr_i,
  output logic on_o
);
  localparam int unsigned EW = $clog2(ENTRY_MS + 1);

  logic [EW-1:0] cnt_q;
  logic          on_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              cnt_q <= '0;
    else if (!req_i)                          cnt_q <= '0;
    else if (tick_i && cnt_q < EW'(ENTRY_MS)) cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        on_q <= 1'b0;
    else if (clr_i)                     on_q <= 1'b0;
    else if (cnt_q >= EW'(ENTRY_MS))    on_q <= 1'b1;
  end

  assign on_o = on_q;
endmodule

// File: rtl/ovp_ctrl.sv
module ovp_ctrl #(
  parameter int unsigned NUM_CELLS     = 4,
  parameter int unsigned MS_PER_S      = 1000,
  parameter int unsigned REL_SHORT_MS  = 2,
  parameter int unsigned REL_LONG_MS   = 64,
  parameter int unsigned TR_MS         = 12,
  parameter int unsigned TEST_DLY_MS   = 32,
  parameter int unsigned TEST_ENTRY_MS = 10
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 tick_i,
  input  logic [NUM_CELLS-1:0] ov_flag_i,
  input  logic [NUM_CELLS-1:0] rel_flag_i,
  input  logic                 ctl_i,
  input  logic                 test_req_i,
  input  logic [2:0]           det_sel_i,
  input  logic                 rel_sel_i,
  input  logic                 pol_sel_i,
  output logic                 chg_ctl_o
);
  import ovp_pkg::*;

  localparam int unsigned DET_MAX = 8 * MS_PER_S;
  localparam int unsigned CW      = $clog2(DET_MAX + 1);
  localparam int unsigned REL_MAX = (REL_LONG_MS > REL_SHORT_MS) ? REL_LONG_MS : REL_SHORT_MS;
  localparam int unsigned RW      = $clog2(REL_MAX + 1);
  localparam int unsigned SW      = 2 * NUM_CELLS + 2;

  logic [SW-1:0]        sync_d, sync_q;
  logic [NUM_CELLS-1:0] ov_s, rel_s;
  logic                 ctl_s, req_s;
  logic                 any_ov, any_rel;

  assign sync_d = {test_req_i, ctl_i, rel_flag_i, ov_flag_i};

  ovp_sync #(.W(SW)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (sync_d),
    .q_o   (sync_q)
  );

  assign ov_s    = sync_q[NUM_CELLS-1:0];
  assign rel_s   = sync_q[2*NUM_CELLS-1:NUM_CELLS];
  assign ctl_s   = sync_q[2*NUM_CELLS];
  assign req_s   = sync_q[2*NUM_CELLS+1];
  assign any_ov  = |ov_s;
  assign any_rel = |rel_s;

  // straps: captured only while reset is held
  logic [2:0] det_sel_q;
  logic       rel_sel_q, pol_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      det_sel_q <= det_sel_i;
      rel_sel_q <= rel_sel_i;
      pol_q     <= pol_sel_i;
    end
  end

  ovp_state_e    state_q;
  logic          test_on, test_clr;
  logic          det_exp, rel_exp, go_ov, go_nrm;
  logic [CW-1:0] det_lim;
  logic [RW-1:0] rel_lim;

  always_comb begin
    if (test_on) det_lim = CW'(TEST_DLY_MS);
    else         det_lim = CW'(det_secs(det_sel_q) * MS_PER_S);
  end

  assign rel_lim = rel_sel_q ? RW'(REL_LONG_MS) : RW'(REL_SHORT_MS);

  ovp_det_timer #(.CW(CW), .TR_MS(TR_MS)) u_det (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (state_q == ST_NORMAL),
    .tick_i  (tick_i),
    .ov_i    (any_ov),
    .lim_i   (det_lim),
    .expire_o(det_exp)
  );

  ovp_rel_timer #(.RW(RW)) u_rel (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (state_q == ST_OVCHG),
    .tick_i  (tick_i),
    .rel_i   (any_rel),
    .lim_i   (rel_lim),
    .expire_o(rel_exp)
  );

  assign go_ov    = (state_q == ST_NORMAL) && det_exp;
  assign go_nrm   = (state_q == ST_OVCHG) && rel_exp;
  assign test_clr = go_ov && test_on;

  ovp_test_latch #(.ENTRY_MS(TEST_ENTRY_MS)) u_test (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(tick_i),
    .req_i (req_s),
    .clr_i (test_clr),
    .on_o  (test_on)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     state_q <= ST_NORMAL;
    else if (go_ov)  state_q <= ST_OVCHG;
    else if (go_nrm) state_q <= ST_NORMAL;
  end

  logic detect;
  assign detect = (state_q == ST_OVCHG) || ctl_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chg_ctl_o <= pol_sel_i;
    else         chg_ctl_o <= detect ^ pol_q;
  end
endmodule

// File: rtl/ovp_ctrl_chk.sv
module ovp_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic any_ov_i,
  input logic any_rel_i,
  input logic ctl_s_i,
  input logic in_ov_i,
  input logic test_on_i,
  input logic pol_i,
  input logic chg_i
);
  // R2: a detection is only entered while some cell flags overcharge
  a_r2_entry_needs_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(in_ov_i) |-> $past(any_ov_i));

  // R4: release only happens with every release flag low
  a_r4_release_all_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(in_ov_i) |-> $past(!any_rel_i));

  // R6: override drives the detection level on the next cycle
  a_r6_ctl_forces: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_s_i |=> (chg_i != pol_i));

  // R7: normal status without override gives the normal level
  a_r7_normal_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!in_ov_i && !ctl_s_i) |=> (chg_i == pol_i));

  // R10: a detection reached in test mode drops the latch
  a_r10_test_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(in_ov_i) && $past(test_on_i)) |-> !test_on_i);
endmodule

bind ovp_ctrl ovp_ctrl_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .any_ov_i (any_ov),
  .any_rel_i(any_rel),
  .ctl_s_i  (ctl_s),
  .in_ov_i  (state_q == ovp_pkg::ST_OVCHG),
  .test_on_i(test_on),
  .pol_i    (pol_q),
  .chg_i    (chg_ctl_o)
);

// File: tb/tb_ovp_ctrl.sv
module tb_ovp_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int N    = 4;
  localparam int MS   = 10;
  localparam int RSH  = 2;
  localparam int RLG  = 16;
  localparam int TR   = 4;
  localparam int TDLY = 5;
  localparam int TENT = 3;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         tick_i = 1'b0;
  logic [N-1:0] ov_flag_i = '0;
  logic [N-1:0] rel_flag_i = '0;
  logic         ctl_i = 1'b0;
  logic         test_req_i = 1'b0;
  logic [2:0]   det_sel_i = 3'd0;
  logic         rel_sel_i = 1'b0;
  logic         pol_sel_i = 1'b0;
  logic         chg_ctl_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  ovp_ctrl #(
    .NUM_CELLS(N), .MS_PER_S(MS), .REL_SHORT_MS(RSH), .REL_LONG_MS(RLG),
    .TR_MS(TR), .TEST_DLY_MS(TDLY), .TEST_ENTRY_MS(TENT)
  ) dut (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i),
    .ov_flag_i(ov_flag_i), .rel_flag_i(rel_flag_i), .ctl_i(ctl_i),
    .test_req_i(test_req_i), .det_sel_i(det_sel_i), .rel_sel_i(rel_sel_i),
    .pol_sel_i(pol_sel_i), .chg_ctl_o(chg_ctl_o)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // reference model state, at tick granularity
  bit m_st, m_act, m_test, m_pol, m_rsel;
  int m_cnt, m_drop, m_rcnt, m_tcnt;
  int m_dsel;

  function automatic int secs(input int sel);
    if (sel == 0) return 1;
    if (sel == 1) return 2;
    if (sel == 2) return 4;
    if (sel == 3) return 6;
    return 8;
  endfunction

  function automatic int dlim();
    return m_test ? TDLY : secs(m_dsel) * MS;
  endfunction

  function automatic int rlim();
    return m_rsel ? RLG : RSH;
  endfunction

  function automatic void m_go_ov();
    m_st = 1'b1; m_act = 1'b0; m_cnt = 0; m_drop = 0; m_rcnt = 0;
    if (m_test) m_test = (m_tcnt >= TENT);
  endfunction

  function automatic void m_pre(input bit ov, input bit rel, input bit req);
    if (!req) m_tcnt = 0;
    if (!m_st) begin
      if (ov) begin m_act = 1'b1; m_drop = 0; end
      if (m_act && ov && m_cnt >= dlim()) m_go_ov();
    end else if (rel) m_rcnt = 0;
  endfunction

  function automatic void m_tick(input bit ov, input bit rel, input bit req);
    if (req && m_tcnt < TENT) m_tcnt++;
    if (!m_st) begin
      if (m_act) begin
        if (m_cnt < dlim()) m_cnt++;
        if (!ov) begin
          if (m_drop >= TR - 1) begin m_act = 1'b0; m_cnt = 0; m_drop = 0; end
          else m_drop++;
        end
      end
    end else if (!rel && m_rcnt < rlim()) m_rcnt++;
    if (m_tcnt >= TENT) m_test = 1'b1;
    if (!m_st && m_act && ov && m_cnt >= dlim()) m_go_ov();
    else if (m_st && !rel && m_rcnt >= rlim()) begin m_st = 1'b0; m_rcnt = 0; end
  endfunction

  task automatic check(input string tag, input logic exp);
    n_chk++;
    if (chg_ctl_o !== exp) begin
      n_bad++;
      $display("FAIL %s: chg_ctl_o=%0b expected %0b at %0t", tag, chg_ctl_o, exp, $time);
    end
  endtask

  // one tick period: inputs, 6 cycles settle, tick, 8 cycles, compare
  task automatic period(input string tag, input logic [N-1:0] ov, input logic [N-1:0] relx,
                        input bit ctl, input bit req);
    logic [N-1:0] rel;
    rel = ov | relx;
    @(negedge clk);
    ov_flag_i = ov; rel_flag_i = rel; ctl_i = ctl; test_req_i = req;
    m_pre(|ov, |rel, req);
    repeat (6) @(negedge clk);
    tick_i = 1'b1;
    @(negedge clk);
    tick_i = 1'b0;
    m_tick(|ov, |rel, req);
    repeat (8) @(negedge clk);
    check(tag, (m_st | ctl) ^ m_pol);
  endtask

  task automatic periods(input int n, input string tag, input logic [N-1:0] ov,
                         input logic [N-1:0] relx, input bit ctl, input bit req);
    for (int i = 0; i < n; i++) period(tag, ov, relx, ctl, req);
  endtask

  task automatic do_reset(input int dsel, input bit rsel, input bit pol);
    @(negedge clk);
    ov_flag_i = '0; rel_flag_i = '0; ctl_i = 1'b0; test_req_i = 1'b0;
    det_sel_i = 3'(dsel); rel_sel_i = rsel; pol_sel_i = pol;
    rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", pol);
    rst_ni = 1'b1;
    m_st = 0; m_act = 0; m_test = 0; m_cnt = 0; m_drop = 0; m_rcnt = 0; m_tcnt = 0;
    m_dsel = dsel; m_rsel = rsel; m_pol = pol;
    repeat (4) @(negedge clk);
    check("R1", pol);
    // R11: later strap changes must be ignored
    det_sel_i = 3'($urandom % 8); rel_sel_i = 1'($urandom); pol_sel_i = 1'($urandom);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    // R1/R11/R2/R12: 10-tick delay, single cell 2
    do_reset(0, 1'b0, 1'b0);
    periods(9, "R2", 4'b0100, 4'b0000, 1'b0, 1'b0);
    check("R12", 1'b0);
    periods(1, "R12", 4'b0100, 4'b0000, 1'b0, 1'b0);
    check("R11", 1'b1);
    // R4: short release, 2 ticks
    periods(1, "R4", 4'b0000, 4'b0000, 1'b0, 1'b0);
    check("R4", 1'b1);
    periods(1, "R4", 4'b0000, 4'b0000, 1'b0, 1'b0);
    check("R4", 1'b0);
    // R3: dropout of TR-1 keeps count
    periods(5, "R3", 4'b0001, 4'b0000, 1'b0, 1'b0);
    periods(3, "R3", 4'b0000, 4'b0000, 1'b0, 1'b0);
    periods(1, "R3", 4'b1000, 4'b0000, 1'b0, 1'b0);
    check("R3", 1'b0);
    periods(1, "R3", 4'b1000, 4'b0000, 1'b0, 1'b0);
    check("R3", 1'b1);
    periods(3, "R4", 4'b0000, 4'b0000, 1'b0, 1'b0);
    // R3: dropout of TR clears
    periods(5, "R3", 4'b0010, 4'b0000, 1'b0, 1'b0);
    periods(4, "R3", 4'b0000, 4'b0000, 1'b0, 1'b0);
    periods(9, "R3", 4'b0010, 4'b0000, 1'b0, 1'b0);
    check("R3", 1'b0);
    periods(1, "R3", 4'b0010, 4'b0000, 1'b0, 1'b0);
    check("R3", 1'b1);
    periods(3, "R4", 4'b0000, 4'b0000, 1'b0, 1'b0);
    // R6: override
    periods(3, "R6", 4'b0000, 4'b0000, 1'b1, 1'b0);
    check("R6", 1'b1);
    periods(2, "R6", 4'b0000, 4'b0000, 1'b0, 1'b0);
    check("R6", 1'b0);
    // R8: short request ignored
    periods(2, "R8", 4'b0000, 4'b0000, 1'b0, 1'b1);
    periods(9, "R8", 4'b0100, 4'b0000, 1'b0, 1'b0);
    check("R8", 1'b0);
    periods(4, "R8", 4'b0000, 4'b0000, 1'b0, 1'b0);
    // R8/R9: entry, latch held, shortened delay with dropout
    periods(3, "R8", 4'b0000, 4'b0000, 1'b0, 1'b1);
    periods(2, "R9", 4'b0000, 4'b0000, 1'b0, 1'b0);
    periods(2, "R9", 4'b0001, 4'b0000, 1'b0, 1'b0);
    periods(3, "R9", 4'b0000, 4'b0000, 1'b0, 1'b0);
    periods(1, "R9", 4'b0001, 4'b0000, 1'b0, 1'b0);
    check("R9", 1'b1);
    periods(3, "R4", 4'b0000, 4'b0000, 1'b0, 1'b0);
    // R10: latch gone, full delay again
    periods(9, "R10", 4'b0001, 4'b0000, 1'b0, 1'b0);
    check("R10", 1'b0);
    periods(1, "R10", 4'b0001, 4'b0000, 1'b0, 1'b0);
    check("R10", 1'b1);
    periods(3, "R4", 4'b0000, 4'b0000, 1'b0, 1'b0);
    // R7/R4/R5: active-low, 20-tick delay, long release
    do_reset(1, 1'b1, 1'b1);
    periods(19, "R7", 4'b1000, 4'b0000, 1'b0, 1'b0);
    check("R7", 1'b1);
    periods(1, "R7", 4'b1000, 4'b0000, 1'b0, 1'b0);
    check("R7", 1'b0);
    periods(10, "R5", 4'b0000, 4'b0000, 1'b0, 1'b0);
    periods(1, "R5", 4'b0000, 4'b0100, 1'b0, 1'b0);
    periods(15, "R5", 4'b0000, 4'b0000, 1'b0, 1'b0);
    check("R5", 1'b0);
    periods(1, "R4", 4'b0000, 4'b0000, 1'b0, 1'b0);
    check("R4", 1'b1);
    // random mix
    for (int k = 0; k < 8; k++) begin
      do_reset($urandom % 8, 1'($urandom), 1'($urandom));
      for (int j = 0; j < 60; j++) begin
        logic [N-1:0] ov, rx;
        ov = ($urandom % 4 != 0) ? 4'($urandom) : 4'b0000;
        rx = ($urandom % 3 == 0) ? 4'($urandom) : 4'b0000;
        period("R2", ov, rx, ($urandom % 16) == 0, ($urandom % 4) == 0);
      end
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule